// File: doc/BRIEF.md
# Packed Float24 Vector Loader

This block sits on a register-write path and builds four-component constant vectors from a stream of 32-bit data words. Each component is a 24-bit float. A setup write chooses the target entry and the input mode. In packed mode, three data words carry all four components. In 32-bit float mode, four data words each carry one IEEE single-precision value, and the block converts each value to the 24-bit format.

When a vector is complete, it is committed to an internal array of `DEPTH` entries (96 by default) at the current index, and the index then moves forward. Consecutive vectors therefore fill consecutive entries without a new setup write. A vector aimed past the end of the array is dropped, and the block raises a one-cycle error flag. A combinational read port exposes any entry so that the array contents can be checked.

Top module: `vec_loader`

## Requirements
- R1: After reset, every entry reads as zero, `range_err` is low, the target index is 0 and the mode is packed.
- R2: In packed mode (`cfg_fp32`=0), a vector commits on the third accepted data word. The entry equals the concatenation {word0, word1, word2}. This gives w=[95:72], z=[71:48], y=[47:24] and x=[23:0].
- R3: In float32 mode (`cfg_fp32`=1), a vector commits only on the fourth data word. Data word i is converted into component 3-i, so the first word lands in w at [95:72] and the last lands in x at [23:0].
- R4: A normal float32 value is converted as follows. The sign is kept, the 8-bit exponent is rebiased from 127 to a 7-bit exponent with bias 63, and the mantissa keeps its upper 16 bits (truncation). For example, 0x3F800000 becomes 0x3F0000 and 0xBFC00000 becomes 0xBF8000.
- R5: A float32 value whose biased exponent is at least 191 saturates to infinity with its sign kept (0x7F0000 or 0xFF0000). An input exponent of all ones gives exponent 0x7F and keeps the upper 16 mantissa bits.
- R6: A float32 value whose biased exponent is 64 or less flushes to a zero that keeps the sign (0x000000 or 0x800000).
- R7: Each commit resets the word count to 0 and raises the target index by one, so back-to-back vectors go to consecutive entries.
- R8: A vector whose target index is DEPTH or more is not stored, and the index does not advance. `range_err` is high for exactly the one cycle after the final word is accepted. A commit within range leaves `range_err` low.
- R9: A setup write does three things: it loads the index and mode, and it discards any partly collected words. If a setup write and a data word arrive in the same cycle, the setup write takes effect and the data word is ignored.
- R10: The committed vector appears on `rd_vector` in the cycle after the clock edge that accepts its final word. An `rd_index` of DEPTH or more reads as zero.
- R11: Fewer data words than the mode needs leave the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_index | input | IDX_W | Target index loaded by a setup write |
| cfg_fp32 | input | 1 | Mode loaded by a setup write: 1 = float32, 0 = packed |
| wr_en | input | 1 | Data word strobe |
| wr_word | input | 32 | Data word |
| rd_index | input | IDX_W | Read port entry select |
| rd_vector | output | 96 | Entry contents {w,z,y,x} |
| range_err | output | 1 | One-cycle pulse when an out-of-range vector is dropped |

## Verification
The assertions assume that the control strobes and `cfg_index` are known at every clock edge once reset is released. They also assume that the mode only changes through a setup write, which the design itself guarantees. The stimulus changes inputs only on the falling clock edge and keeps strobes at defined 0 or 1 values between operations. It reaches out-of-range indices only through setup writes, so every index the assertions observe comes from a setup write or a commit.

// File: rtl/vl_pkg.sv
package vl_pkg;

    localparam int WORD_W  = 32;
    localparam int COMP_W  = 24;
    localparam int NCOMP   = 4;
    localparam int VEC_W   = COMP_W * NCOMP;
    localparam int CNT_W   = $clog2(NCOMP);

    typedef logic [VEC_W-1:0] vec_t;
    typedef logic [NCOMP-1:0][WORD_W-1:0] wordset_t;

    typedef enum logic {
        MODE_PACKED = 1'b0,
        MODE_FP32   = 1'b1
    } mode_e;

    typedef struct packed {
        logic       sign;
        logic [6:0] exp;
        logic [15:0] man;
    } f24_t;

    // Single-precision to 24-bit float: rebias 127 -> 63, truncate mantissa,
    // saturate large magnitudes, flush small magnitudes to signed zero.
    function automatic f24_t f32_to_f24(input logic [WORD_W-1:0] v);
        f24_t       r;
        logic [7:0] e;
        logic [7:0] reb;
        e      = v[30:23];
        reb    = e - 8'd64;
        r.sign = v[31];
        if (e == 8'hFF) begin
            r.exp = 7'h7F;
            r.man = v[22:7];
        end else if (e <= 8'd64) begin
            r.exp = 7'h00;
            r.man = 16'h0000;
        end else if (e >= 8'd191) begin
            r.exp = 7'h7F;
            r.man = 16'h0000;
        end else begin
            r.exp = reb[6:0];
            r.man = v[22:7];
        end
        return r;
    endfunction

endpackage

// File: rtl/vl_collect.sv
module vl_collect
    import vl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 setup_i,
    input  mode_e                mode_i,
    input  logic                 word_vld_i,
    input  logic [WORD_W-1:0]    word_i,
    output logic                 done_o,
    output wordset_t             words_o,
    output mode_e                mode_o,
    output logic [CNT_W-1:0]     cnt_o
);

    logic [CNT_W-1:0] cnt_q;
    mode_e            mode_q;
    wordset_t         buf_q;
    logic [CNT_W-1:0] last_slot;

    assign last_slot = (mode_q == MODE_FP32) ? CNT_W'(NCOMP - 1) : CNT_W'(NCOMP - 2);
    assign done_o    = word_vld_i && !setup_i && (cnt_q == last_slot);
    assign mode_o    = mode_q;
    assign cnt_o     = cnt_q;

    // The final word bypasses the buffer so the commit lands on the same edge.
    for (genvar g = 0; g < NCOMP; g++) begin : g_slot
        assign words_o[g] = (cnt_q == CNT_W'(g)) ? word_i : buf_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= MODE_PACKED;
            buf_q  <= '0;
        end else if (setup_i) begin
            cnt_q  <= '0;
            mode_q <= mode_i;
        end else if (word_vld_i) begin
            buf_q[cnt_q] <= word_i;
            if (done_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/vl_unpack.sv
module vl_unpack
    import vl_pkg::*;
(
    input  mode_e    mode_i,
    input  wordset_t words_i,
    output vec_t     vec_o
);

    vec_t packed_vec;
    vec_t fp_vec;

    // Three words laid end to end already form {w,z,y,x}.
    assign packed_vec = {words_i[0], words_i[1], words_i[2]};

    for (genvar g = 0; g < NCOMP; g++) begin : g_cvt
        f24_t c;
        assign c = f32_to_f24(words_i[g]);
        assign fp_vec[(NCOMP-1-g)*COMP_W +: COMP_W] = c;
    end

    assign vec_o = (mode_i == MODE_FP32) ? fp_vec : packed_vec;

endmodule

// File: rtl/vl_store.sv
module vl_store
    import vl_pkg::*;
#(
    parameter int DEPTH = 96,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             setup_i,
    input  logic [IDX_W-1:0] setup_idx_i,
    input  logic             commit_i,
    input  vec_t             vec_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output vec_t             rd_data_o,
    output logic             err_o,
    output logic [IDX_W-1:0] idx_o
);

    localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEPTH);

    vec_t             mem_q [DEPTH];
    logic [IDX_W-1:0] idx_q;
    logic             err_q;
    logic             in_range;

    assign in_range  = {1'b0, idx_q} < LIM;
    assign rd_data_o = ({1'b0, rd_idx_i} < LIM) ? mem_q[rd_idx_i] : '0;
    assign err_o     = err_q;
    assign idx_o     = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
            err_q <= 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            err_q <= 1'b0;
            if (setup_i) begin
                idx_q <= setup_idx_i;
            end else if (commit_i) begin
                if (in_range) begin
                    mem_q[idx_q] <= vec_i;
                    idx_q        <= idx_q + IDX_W'(1);
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/vec_loader.sv
module vec_loader
    import vl_pkg::*;
#(
    parameter int DEPTH = 96,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_index,
    input  logic             cfg_fp32,
    input  logic             wr_en,
    input  logic [31:0]      wr_word,
    input  logic [IDX_W-1:0] rd_index,
    output logic [95:0]      rd_vector,
    output logic             range_err
);

    logic             commit_w;
    wordset_t         words_w;
    mode_e            mode_w;
    logic [CNT_W-1:0] cnt_w;
    vec_t             vec_w;
    logic [IDX_W-1:0] idx_w;
    mode_e            cfg_mode;

    assign cfg_mode = cfg_fp32 ? MODE_FP32 : MODE_PACKED;

    vl_collect u_collect (
        .clk        (clk),
        .rst        (rst),
        .setup_i    (cfg_we),
        .mode_i     (cfg_mode),
        .word_vld_i (wr_en),
        .word_i     (wr_word),
        .done_o     (commit_w),
        .words_o    (words_w),
        .mode_o     (mode_w),
        .cnt_o      (cnt_w)
    );

    vl_unpack u_unpack (
        .mode_i  (mode_w),
        .words_i (words_w),
        .vec_o   (vec_w)
    );

    vl_store #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .setup_i     (cfg_we),
        .setup_idx_i (cfg_index),
        .commit_i    (commit_w),
        .vec_i       (vec_w),
        .rd_idx_i    (rd_index),
        .rd_data_o   (rd_vector),
        .err_o       (range_err),
        .idx_o       (idx_w)
    );

endmodule

// File: rtl/vl_checker.sv
module vl_checker #(
    parameter int DEPTH = 96,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             setup,
    input logic             wvld,
    input logic             commit,
    input logic             fp32,
    input logic [1:0]       cnt,
    input logic [IDX_W-1:0] idx,
    input logic             err
);

    localparam logic [IDX_W:0] LIM = (IDX_W+1)'(DEPTH);

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        !fp32 |-> cnt <= 2'd2);

    assert_setup_clear_R9: assert property (@(posedge clk) disable iff (rst)
        setup |=> cnt == 2'd0);

    assert_advance_R7: assert property (@(posedge clk) disable iff (rst)
        (commit && ({1'b0, idx} < LIM)) |=> idx == $past(idx) + IDX_W'(1));

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> ($past(commit) && ({1'b0, $past(idx)} >= LIM)));

    assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        err |=> !err);

    assert_partial_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (wvld && !setup && !commit) |=> idx == $past(idx));

endmodule

bind vec_loader vl_checker #(.DEPTH(DEPTH)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .setup  (cfg_we),
    .wvld   (wr_en),
    .commit (commit_w),
    .fp32   (mode_w == vl_pkg::MODE_FP32),
    .cnt    (cnt_w),
    .idx    (idx_w),
    .err    (range_err)
);

// File: tb/vec_loader_bench.sv
`timescale 1ns/1ps
module vec_loader_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_index = '0;
    logic        cfg_fp32 = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_word = '0;
    logic [6:0]  rd_index = '0;
    logic [95:0] rd_vector;
    logic        range_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    vec_loader u_vec_loader (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_index(cfg_index),
        .cfg_fp32(cfg_fp32), .wr_en(wr_en), .wr_word(wr_word),
        .rd_index(rd_index), .rd_vector(rd_vector), .range_err(range_err)
    );

    task automatic check(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_entry(input logic [6:0] idx, input logic [95:0] exp, input string tag);
        rd_index = idx;
        #0.5;
        check(rd_vector === exp, tag, rd_vector, exp);
    endtask

    task automatic setup(input logic [6:0] idx, input bit fp32);
        cfg_we = 1'b1; cfg_index = idx; cfg_fp32 = fp32;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic push(input logic [31:0] w);
        wr_en = 1'b1; wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check_entry(7'd0,  '0, "R1 entry0");
        check_entry(7'd50, '0, "R1 entry50");
        check_entry(7'd95, '0, "R1 entry95");
        check(range_err === 1'b0, "R1 err low", {95'd0, range_err}, 96'd0);
        // default index 0, packed mode
        push(32'hAAAA_0001); push(32'hBBBB_0002); push(32'hCCCC_0003);
        check_entry(7'd0, 96'hAAAA0001_BBBB0002_CCCC0003, "R1 default idx/mode");
    endtask

    task automatic t_packed;
        setup(7'd5, 1'b0);
        push(32'h1122_3344); push(32'h5566_7788);
        check_entry(7'd5, '0, "R11 partial packed");
        push(32'h99AA_BBCC);
        check_entry(7'd5, 96'h11223344_55667788_99AABBCC, "R2 R10 packed layout");
        check(rd_vector[23:0] === 24'hAABBCC, "R2 x field", {72'd0, rd_vector[23:0]}, 96'hAABBCC);
        check(rd_vector[95:72] === 24'h112233, "R2 w field", {72'd0, rd_vector[95:72]}, 96'h112233);
        check_entry(7'd96, '0, "R10 out-of-range read");
    endtask

    task automatic t_clear;
        setup(7'd10, 1'b0);
        push(32'hDEAD_0001); push(32'hDEAD_0002);
        setup(7'd10, 1'b0);
        push(32'h0000_000C); push(32'h0000_000D); push(32'h0000_000E);
        check_entry(7'd10, 96'h0000000C_0000000D_0000000E, "R9 setup clears partial");
    endtask

    task automatic t_seq;
        setup(7'd20, 1'b0);
        for (int i = 0; i < 6; i++) push(32'h2000_0000 + i);
        check_entry(7'd20, 96'h20000000_20000001_20000002, "R7 first vector");
        check_entry(7'd21, 96'h20000003_20000004_20000005, "R7 second vector");
    endtask

    task automatic t_float;
        setup(7'd30, 1'b1);
        push(32'h3F80_0000); push(32'h4000_0000); push(32'hBFC0_0000);
        check_entry(7'd30, '0, "R3 three words not enough");
        push(32'h7F00_0000);
        check_entry(7'd30, 96'h3F0000_400000_BF8000_7F0000, "R3 R4 R5 float order/convert");
    endtask

    task automatic t_edges;
        setup(7'd31, 1'b1);
        push(32'h2000_0000); push(32'hA000_0000); push(32'h7F80_0000); push(32'hFF7F_FFFF);
        check_entry(7'd31, 96'h000000_800000_7F0000_FF0000, "R6 R5 flush and saturate");
    endtask

    task automatic t_mode_switch;
        setup(7'd50, 1'b1);
        push(32'h1111_1111);
        setup(7'd50, 1'b0);
        push(32'h0102_0304); push(32'h0506_0708); push(32'h090A_0B0C);
        check_entry(7'd50, 96'h01020304_05060708_090A0B0C, "R9 mode reload");
    endtask

    task automatic t_priority;
        cfg_we = 1'b1; cfg_index = 7'd40; cfg_fp32 = 1'b0;
        wr_en = 1'b1; wr_word = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0; wr_en = 1'b0;
        push(32'h4000_0001); push(32'h4000_0002); push(32'h4000_0003);
        check_entry(7'd40, 96'h40000001_40000002_40000003, "R9 setup beats data");
    endtask

    task automatic t_range;
        setup(7'd95, 1'b0);
        push(32'h9500_0001); push(32'h9500_0002); push(32'h9500_0003);
        check(range_err === 1'b0, "R8 no err in range", {95'd0, range_err}, 96'd0);
        check_entry(7'd95, 96'h95000001_95000002_95000003, "R8 last entry stored");
        push(32'h9600_0001); push(32'h9600_0002);
        check(range_err === 1'b0, "R8 no err before final", {95'd0, range_err}, 96'd0);
        push(32'h9600_0003);
        check(range_err === 1'b1, "R8 err pulse", {95'd0, range_err}, 96'd1);
        @(negedge clk);
        check(range_err === 1'b0, "R8 err one cycle", {95'd0, range_err}, 96'd0);
        check_entry(7'd95, 96'h95000001_95000002_95000003, "R8 entry95 untouched");
        check_entry(7'd0, 96'hAAAA0001_BBBB0002_CCCC0003, "R8 no wrap to 0");
        push(32'h1); push(32'h2); push(32'h3);
        check(range_err === 1'b1, "R8 index held past end", {95'd0, range_err}, 96'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_packed();
        t_clear();
        t_seq();
        t_float();
        t_edges();
        t_mode_switch();
        t_priority();
        t_range();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule